// File: doc/BRIEF.md
# Five-Channel Buffered PWM Timer

The block is a bank of five down-counting timers, each driving one PWM output pin, configured through a small memory-mapped register bus. Every channel owns a count buffer and a compare buffer. Software writes these buffers at any time, and they reach the live counter only at defined moments: while the channel's manual-update bit is held, or when the running counter expires with auto-reload enabled. A running period is therefore never disturbed by a register write.

Ticks come from a shared generator. Two 8-bit prescalers divide the system clock, one serving channels 0–1 and the other channels 2–4. Each channel then divides its prescaler's tick by a selectable power of two. A single control word holds every channel's start, manual-update, invert and auto-reload bits. The bit layout is irregular: there is an unused group after channel 0, and the last channel's auto-reload bit is moved into the position the invert bit has in the other groups.

Top module: `multi_pwm_timer`

## Requirements
- R1: Writes to offsets 0x00 (prescalers), 0x04 (divider selects), 0x08 (control), 0x0C+0x0C*ch (count buffer) and 0x10+0x0C*ch (compare buffer) are stored. A read of the same offset returns the last value written, with the buffers zero-extended from CNT_W bits. Any other offset reads 0, and writes to it are ignored.
- R2: Channels 0–1 tick at clk/(P0+1) and channels 2–4 at clk/(P1+1), where P0 is bits 7:0 and P1 is bits 15:8 of offset 0x00. This rate is then divided by 2^k, where k is bits 4*ch+3:4*ch of offset 0x04. Values of k above 4 behave as 4.
- R3: A running channel counts down from its loaded count value N to 0, one step per tick, so one period lasts N+1 ticks.
- R4: Within a period the output (before inversion) is low while the counter is above the compare value C and high from the tick on which the counter equals C down to 0. The high time is therefore C+1 ticks. If C is greater than N and not all ones, the output stays low for the whole period.
- R5: A compare value of all ones keeps the output (before inversion) high for the whole period.
- R6: In the control word, channel 0 uses bit group 0 (bits 3:0) and channel n≥1 uses group n+1 (bits 4n+7:4n+4). Group 1 is unused. Within a group, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload. Channel 4 uses group 5: start at bit 20, manual update at bit 21, auto-reload at bit 22, and it has no invert bit.
- R7: While a channel's manual-update bit is 1, the channel copies its count and compare buffers into the live counter and compare every cycle and does not count. At all other times, writes to the buffers take effect only at the next reload.
- R8: When the counter reaches 0 on a tick with auto-reload set, the buffers are reloaded for the next period. With auto-reload clear, the channel halts and its pin goes low. It stays halted until a manual update.
- R9: With the invert bit set, the pin is the complement of the pre-inversion output while the channel runs.
- R10: A cleared start bit freezes the counter and drives the pin low. Setting start again resumes from the frozen count.
- R11: After a synchronous reset all registers read 0 and all pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | 5 | PWM pins, bit ch for channel ch |

## Verification
The hardest condition to reach from the ports is a buffer write that lands in the middle of a running period. The old period must finish untouched and the new values must appear only after the next reload. The stimulus rewrites a running channel's count buffer without a manual update, waits past one reload, and measures the following edge-to-edge period. The hold behaviour of a manual-update bit that stays asserted is reached by leaving it set alongside start and confirming that no edge appears. The shifted auto-reload bit of the last channel is probed twice: once with bit 22 set, where the waveform repeats, and once with only bit 23 set, where exactly one pulse is produced.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int NUM_CH = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int GRP_W  = 4;
    localparam int SEL_W  = 4;

    localparam logic [ADDR_W-1:0] OFS_PRESCALE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIVSEL   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h08;

    typedef struct packed {
        logic start;
        logic manual;
        logic invert;
        logic autoreload;
    } ch_ctrl_t;

    // Control group used by a channel: group 1 is skipped.
    function automatic int ctrl_group(input int ch);
        return (ch == 0) ? 0 : ch + 1;
    endfunction

    function automatic ch_ctrl_t decode_ctrl(input logic [DATA_W-1:0] word, input int ch);
        ch_ctrl_t r;
        int b;
        b = GRP_W * ctrl_group(ch);
        r.start  = word[b];
        r.manual = word[b+1];
        if (ch == NUM_CH - 1) begin
            r.invert     = 1'b0;
            r.autoreload = word[b+2];
        end else begin
            r.invert     = word[b+2];
            r.autoreload = word[b+3];
        end
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] cnt_buf_ofs(input int ch);
        return ADDR_W'(12 + 12 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_buf_ofs(input int ch);
        return ADDR_W'(16 + 12 * ch);
    endfunction

    // Channels 0 and 1 share prescaler 0, the rest use prescaler 1.
    function automatic int prescaler_of(input int ch);
        return (ch < 2) ? 0 : 1;
    endfunction

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [DATA_W-1:0]                   rdata,
    output logic [2*PRE_W-1:0]                  pre_cfg,
    output logic [SEL_W*NUM_CH-1:0]             div_cfg,
    output ch_ctrl_t [NUM_CH-1:0]               ch_ctrl,
    output logic [NUM_CH-1:0][CNT_W-1:0]        cnt_buf,
    output logic [NUM_CH-1:0][CNT_W-1:0]        cmp_buf
);

    logic [DATA_W-1:0] pre_q;
    logic [DATA_W-1:0] div_q;
    logic [DATA_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            div_q   <= '0;
            ctrl_q  <= '0;
            cnt_buf <= '0;
            cmp_buf <= '0;
        end else if (we) begin
            if (addr == OFS_PRESCALE) pre_q  <= wdata;
            if (addr == OFS_DIVSEL)   div_q  <= wdata;
            if (addr == OFS_CTRL)     ctrl_q <= wdata;
            for (int c = 0; c < NUM_CH; c++) begin
                if (addr == cnt_buf_ofs(c)) cnt_buf[c] <= wdata[CNT_W-1:0];
                if (addr == cmp_buf_ofs(c)) cmp_buf[c] <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_PRESCALE) rdata = pre_q;
        if (addr == OFS_DIVSEL)   rdata = div_q;
        if (addr == OFS_CTRL)     rdata = ctrl_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == cnt_buf_ofs(c)) rdata = DATA_W'(cnt_buf[c]);
            if (addr == cmp_buf_ofs(c)) rdata = DATA_W'(cmp_buf[c]);
        end
    end

    assign pre_cfg = pre_q[2*PRE_W-1:0];
    assign div_cfg = div_q[SEL_W*NUM_CH-1:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        assign ch_ctrl[c] = decode_ctrl(ctrl_q, c);
    end

    // R1: a control write is what the control register holds next cycle
    assert_ctrl_readback_R1: assert property (@(posedge clk) disable iff (rst)
        (we && addr == OFS_CTRL) |=> (ctrl_q == $past(wdata)));

    // R1: a prescaler write is what the prescaler register holds next cycle
    assert_pre_readback_R1: assert property (@(posedge clk) disable iff (rst)
        (we && addr == OFS_PRESCALE) |=> (pre_q == $past(wdata)));

endmodule

// File: rtl/pwmt_tickgen.sv
module pwmt_tickgen
    import pwmt_pkg::*;
#(
    parameter int PRE_W        = 8,
    parameter int DIV_LOG2_MAX = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2*PRE_W-1:0]      pre_cfg,
    input  logic [SEL_W*NUM_CH-1:0] div_cfg,
    output logic [NUM_CH-1:0]       tick
);

    localparam int DCW = (DIV_LOG2_MAX < 1) ? 1 : DIV_LOG2_MAX;

    logic [1:0] pre_tick;

    for (genvar p = 0; p < 2; p++) begin : g_pre
        logic [PRE_W-1:0] pc;
        logic [PRE_W-1:0] pval;
        assign pval        = pre_cfg[p*PRE_W +: PRE_W];
        assign pre_tick[p] = (pc >= pval);
        always_ff @(posedge clk) begin
            if (rst)              pc <= '0;
            else if (pre_tick[p]) pc <= '0;
            else                  pc <= pc + PRE_W'(1);
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_div
        localparam int PS = prescaler_of(c);
        logic [SEL_W-1:0] k_raw;
        logic [SEL_W-1:0] k_eff;
        logic [DCW-1:0]   lim;
        logic [DCW-1:0]   dc;
        assign k_raw   = div_cfg[SEL_W*c +: SEL_W];
        assign k_eff   = (k_raw > SEL_W'(DIV_LOG2_MAX)) ? SEL_W'(DIV_LOG2_MAX) : k_raw;
        assign lim     = DCW'((1 << k_eff) - 1);
        assign tick[c] = pre_tick[PS] && (dc >= lim);
        always_ff @(posedge clk) begin
            if (rst)               dc <= '0;
            else if (pre_tick[PS]) dc <= (dc >= lim) ? '0 : dc + DCW'(1);
        end
    end

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  ch_ctrl_t         ctrl,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic             pwm
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp_act;
    logic             lvl;
    logic             halted;
    logic             run;
    logic [CNT_W-1:0] cnt_dec;
    logic             load_lvl;

    assign run      = ctrl.start && !halted;
    assign cnt_dec  = cnt - CNT_W'(1);
    // Level at the start of a freshly loaded period.
    assign load_lvl = (&cmp_buf) || (cnt_buf == cmp_buf);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cmp_act <= '0;
            lvl     <= 1'b0;
            halted  <= 1'b0;
        end else if (ctrl.manual) begin
            cnt     <= cnt_buf;
            cmp_act <= cmp_buf;
            lvl     <= load_lvl;
            halted  <= 1'b0;
        end else if (run && tick) begin
            if (cnt == '0) begin
                if (ctrl.autoreload) begin
                    cnt     <= cnt_buf;
                    cmp_act <= cmp_buf;
                    lvl     <= load_lvl;
                end else begin
                    halted  <= 1'b1;
                end
            end else begin
                cnt <= cnt_dec;
                if (cnt_dec == cmp_act) lvl <= 1'b1;
            end
        end
    end

    assign pwm = run && (lvl ^ ctrl.invert);

    // R3: each tick in a running period lowers the count by exactly one
    assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
        (run && !ctrl.manual && tick && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R7: a held manual update copies both buffers into the live registers
    assert_manual_load_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.manual |=> (cnt == $past(cnt_buf) && cmp_act == $past(cmp_buf)));

    // R8: expiry without auto-reload halts the channel
    assert_one_shot_halt_R8: assert property (@(posedge clk) disable iff (rst)
        (run && !ctrl.manual && tick && cnt == '0 && !ctrl.autoreload) |=> halted);

    // R5: an all-ones live compare always means the high level
    assert_full_duty_R5: assert property (@(posedge clk) disable iff (rst)
        (&cmp_act) |-> lvl);

    // R10: a cleared start with no manual update leaves the count untouched
    assert_hold_count_R10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.start && !ctrl.manual) |=> $stable(cnt));

endmodule

// File: rtl/multi_pwm_timer.sv
module multi_pwm_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int PRE_W        = 8,
    parameter int DIV_LOG2_MAX = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [4:0]        pwm_o
);

    logic [2*PRE_W-1:0]           pre_cfg;
    logic [SEL_W*NUM_CH-1:0]      div_cfg;
    ch_ctrl_t [NUM_CH-1:0]        ch_ctrl;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf;
    logic [NUM_CH-1:0]            tick;

    pwmt_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .pre_cfg (pre_cfg),
        .div_cfg (div_cfg),
        .ch_ctrl (ch_ctrl),
        .cnt_buf (cnt_buf),
        .cmp_buf (cmp_buf)
    );

    pwmt_tickgen #(.PRE_W(PRE_W), .DIV_LOG2_MAX(DIV_LOG2_MAX)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .pre_cfg (pre_cfg),
        .div_cfg (div_cfg),
        .tick    (tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwmt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick[c]),
            .ctrl    (ch_ctrl[c]),
            .cnt_buf (cnt_buf[c]),
            .cmp_buf (cmp_buf[c]),
            .pwm     (pwm_o[c])
        );
    end

endmodule

// File: tb/test_multi_pwm_timer.sv
module test_multi_pwm_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  pwm_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    multi_pwm_timer i_multi_pwm_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o)
    );

    typedef struct {
        int    ch;
        int    per;
        int    hi;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    function automatic int grp(input int ch);
        return (ch == 0) ? 0 : ch + 1;
    endfunction
    function automatic logic [31:0] b_start(input int ch);  return 32'd1 << (4*grp(ch));     endfunction
    function automatic logic [31:0] b_man(input int ch);    return 32'd1 << (4*grp(ch) + 1); endfunction
    function automatic logic [31:0] b_inv(input int ch);    return 32'd1 << (4*grp(ch) + 2); endfunction
    function automatic logic [31:0] b_ar(input int ch);
        return (ch == 4) ? (32'd1 << 22) : (32'd1 << (4*grp(ch) + 3));
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Load buffers, pulse manual update, then apply the run bits.
    task automatic setup(input int ch, input logic [31:0] pre, input logic [31:0] dv,
                         input int n, input int cmp, input logic [31:0] run_bits);
        wr(8'h00, pre);
        wr(8'h04, dv);
        wr(8'(12 + 12*ch), 32'(n));
        wr(8'(16 + 12*ch), 32'(cmp));
        wr(8'h08, b_man(ch));
        wr(8'h08, run_bits);
    endtask

    task automatic expect_wave(input int ch, input int per, input int hi, input string tag);
        exp_t e;
        e.ch = ch; e.per = per; e.hi = hi; e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    // Count rising edges and the high samples over a window of cycles.
    task automatic observe(input int ch, input int cycles, output int rises, output int highs);
        logic prev;
        rises = 0; highs = 0;
        @(negedge clk);
        prev = pwm_o[ch];
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_o[ch] && !prev) rises++;
            if (pwm_o[ch]) highs++;
            prev = pwm_o[ch];
        end
    endtask

    // Monitor: measures one full waveform per queued item.
    initial begin
        forever begin
            exp_t e;
            int   h;
            int   l;
            logic prev;
            wait (sb_q.size() > 0);
            e = sb_q[0];
            @(negedge clk);
            prev = pwm_o[e.ch];
            forever begin
                @(negedge clk);
                if (pwm_o[e.ch] && !prev) break;
                prev = pwm_o[e.ch];
            end
            h = 1;
            forever begin
                @(negedge clk);
                if (!pwm_o[e.ch]) break;
                h++;
            end
            l = 1;
            forever begin
                @(negedge clk);
                if (pwm_o[e.ch]) break;
                l++;
            end
            check(h + l == e.per, {e.tag, " period"}, h + l, e.per);
            check(h == e.hi, {e.tag, " high"}, h, e.hi);
            void'(sb_q.pop_front());
        end
    end

    initial begin
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int r;
        int hs;
        int bad;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: everything zero after reset
        bad = 0;
        for (int a = 0; a <= 8'h40; a += 4) begin
            rd(8'(a), d);
            if (d != 0) bad++;
        end
        check(bad == 0, "R11 registers zero", bad, 0);
        check(pwm_o == 5'd0, "R11 pins low", int'(pwm_o), 0);

        // R1: readback and unmapped offsets
        wr(8'h00, 32'hA5A5_0302);
        rd(8'h00, d);
        check(d == 32'hA5A5_0302, "R1 prescaler readback", int'(d), int'(32'hA5A5_0302));
        wr(8'h08, 32'h8000_0001);
        rd(8'h08, d);
        check(d == 32'h8000_0001, "R1 control readback", int'(d), int'(32'h8000_0001));
        wr(8'h3C, 32'hABCD_1234);
        rd(8'h3C, d);
        check(d == 32'h0000_1234, "R1 count buffer zero-extended", int'(d), 32'h1234);
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h44, d);
        check(d == 32'h0, "R1 unmapped offset reads zero", int'(d), 0);
        wr(8'h08, 32'h0);

        // R3 R4: base rate, N=9 C=3
        setup(0, 32'h0, 32'h0, 9, 3, b_start(0) | b_ar(0));
        expect_wave(0, 10, 4, "R3 R4 ch0 N9 C3");

        // R7: buffer write while running reaches the pin only after reload
        wr(8'h0C, 32'd19);
        repeat (30) @(negedge clk);
        expect_wave(0, 20, 4, "R7 buffered count");

        // R7: held manual update freezes the channel
        setup(0, 32'h0, 32'h0, 9, 3, b_man(0) | b_start(0) | b_ar(0));
        observe(0, 50, r, hs);
        check(r == 0 && hs == 0, "R7 manual held no edges", r + hs, 0);
        wr(8'h08, b_start(0) | b_ar(0));
        expect_wave(0, 10, 4, "R7 after release");

        // R2: prescaler 0 = 2, divider 2^1 -> 6 cycles per tick
        setup(0, 32'h0000_0002, 32'h1, 4, 1, b_start(0) | b_ar(0));
        expect_wave(0, 30, 12, "R2 ch0 P2 k1");

        // R2: channel 2 uses bits 15:8, divider 2^2 -> 8 cycles per tick
        setup(2, 32'h0000_0100, 32'h0000_0200, 3, 0, b_start(2) | b_ar(2));
        expect_wave(2, 32, 8, "R2 ch2 upper prescaler");

        // R2: divider select above 4 clamps to 2^4
        setup(1, 32'h0, 32'h0000_0070, 2, 0, b_start(1) | b_ar(1));
        expect_wave(1, 48, 16, "R2 ch1 divider clamp");

        // R9 R6: channel 3 inverted (group 4, bit 18)
        setup(3, 32'h0, 32'h0, 7, 2, b_start(3) | b_ar(3) | b_inv(3));
        expect_wave(3, 8, 5, "R9 R6 ch3 inverted");

        // R6: channel 4 auto-reload at bit 22, no inversion
        setup(4, 32'h0, 32'h0, 5, 1, (32'd1 << 20) | (32'd1 << 22));
        expect_wave(4, 6, 2, "R6 ch4 bit22 reload");

        // R6: channel 4 with only bit 23 is one-shot
        setup(4, 32'h0, 32'h0, 5, 1, (32'd1 << 20) | (32'd1 << 23));
        observe(4, 60, r, hs);
        check(r == 1, "R6 ch4 bit23 is not reload", r, 1);

        // R5: all-ones compare is 100% duty
        setup(0, 32'h0, 32'h0, 4, 32'hFFFF, b_start(0) | b_ar(0));
        observe(0, 60, r, hs);
        check(hs == 60, "R5 full duty", hs, 60);

        // R10: cleared start forces pin low, restart resumes
        wr(8'h08, b_ar(0));
        observe(0, 20, r, hs);
        check(hs == 0, "R10 stopped pin low", hs, 0);
        wr(8'h08, b_start(0) | b_ar(0));
        observe(0, 20, r, hs);
        check(hs == 20, "R10 resume", hs, 20);

        // R4: compare above count keeps output low
        setup(0, 32'h0, 32'h0, 4, 9, b_start(0) | b_ar(0));
        observe(0, 60, r, hs);
        check(hs == 0, "R4 compare above count", hs, 0);

        // R8: without auto-reload one pulse then halt
        setup(0, 32'h0, 32'h0, 4, 1, b_start(0));
        observe(0, 100, r, hs);
        check(r == 1, "R8 single pulse", r, 1);
        check(pwm_o[0] == 1'b0, "R8 halted low", int'(pwm_o[0]), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule